// File: doc/BRIEF.md
# Output Driver Impedance Update Sequencer

This block decides when a freshly calibrated output-driver impedance code may reach the data drivers. A calibration engine outside the block supplies the code. A flag from the reference sensing marks a reference pin that is open or tied to the supply, and in that case the block substitutes the maximum-impedance code. The block also receives three per-cycle indications, sampled at the clock edge, that the data bus is high-impedance in that cycle. These are a write operation, a deselect, and an output enable that is deasserted with setup and hold met around the edge. The code register changes only at an edge where one of these holds, so the drivers never change strength while a read is driving the bus.

After reset the outputs are treated as high-impedance, and the code is refreshed on every edge during a fixed settling period. Once that period has run out, a sticky flag reports that the impedance is fully updated. From then on, a code that arrives while the bus is driving waits. The newest value is applied at the first following high-impedance edge.

Top module: `imp_update_seq`

## Requirements
- R1: While reset is sampled high, drv_code is all ones (maximum impedance), settled is 0 and upd_strobe is 0.
- R2: settled goes to 1 at exactly the SETTLE_CYCLES-th rising edge after reset is released, then stays 1 until reset is applied again.
- R3: While settled is 0, every edge loads the selected code into drv_code, whatever the operation inputs are.
- R4: While settled is 1 and wr_op, desel_op and oe_off are all 0, drv_code keeps its value even if cal_code or ref_open change.
- R5: An edge with wr_op = 1 loads the selected code into drv_code.
- R6: An edge with desel_op = 1 loads the selected code into drv_code.
- R7: An edge with oe_off = 1 loads the selected code into drv_code.
- R8: When ref_open = 1 the selected code is all ones; otherwise it is cal_code.
- R9: A code that changes one or more times during read cycles is applied with its latest value at the first following high-impedance edge.
- R10: upd_strobe is 1 for exactly the cycle after an edge that changed drv_code, and is 0 otherwise, including after a load of an unchanged code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_code | input | CODE_W | Calibrated impedance code from the calibration engine |
| ref_open | input | 1 | Reference pin open or supply-tied; forces the maximum-impedance code |
| wr_op | input | 1 | Write cycle at this edge (bus high-impedance) |
| desel_op | input | 1 | Deselect cycle at this edge (bus high-impedance) |
| oe_off | input | 1 | Output enable deasserted around this edge with setup and hold met |
| drv_code | output | CODE_W | Impedance code applied to the data drivers |
| settled | output | 1 | Power-up impedance update complete (sticky until reset) |
| upd_strobe | output | 1 | One-cycle pulse after drv_code changed |

## Verification
The bench uses CODE_W = 6 and keeps the full default SETTLE_CYCLES = 4096. This lets it walk through the whole settling period with a new code on every edge and check the exact edge on which settled rises, without a shortened window that could hide an off-by-one in the counter. A 6-bit code is wide enough that the all-ones forced code differs from every calibrated value the bench drives. It also makes the strobe on an unchanged reload observable.

// File: rtl/imp_seq_pkg.sv
package imp_seq_pkg;

    // Per-edge bus operation indications that imply high-impedance outputs
    typedef struct packed {
        logic wr;
        logic desel;
        logic oe_off;
    } bus_ops_t;

    // Reason an update window opened at this edge
    typedef enum logic [2:0] {
        WIN_NONE   = 3'd0,
        WIN_SETTLE = 3'd1,
        WIN_WRITE  = 3'd2,
        WIN_DESEL  = 3'd3,
        WIN_OE     = 3'd4
    } win_src_e;

    function automatic logic ops_hiz(input bus_ops_t o);
        return o.wr | o.desel | o.oe_off;
    endfunction

    function automatic win_src_e classify(input bus_ops_t o, input logic settling);
        if (settling)     return WIN_SETTLE;
        else if (o.wr)    return WIN_WRITE;
        else if (o.desel) return WIN_DESEL;
        else if (o.oe_off) return WIN_OE;
        else              return WIN_NONE;
    endfunction

endpackage

// File: rtl/imp_target_sel.sv
module imp_target_sel #(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0] cal_code,
    input  logic              ref_open,
    output logic [CODE_W-1:0] target
);
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

    // R8: open or supply-tied reference selects the weakest drive
    always_comb begin
        if (ref_open) target = MAX_CODE;
        else          target = cal_code;
    end
endmodule

// File: rtl/imp_settle_timer.sv
module imp_settle_timer #(
    parameter int SETTLE_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst,
    output logic settled
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            settled <= 1'b0;
        end else if (!settled) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) settled <= 1'b1;
        end
    end

    // R2
    settled_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        settled |=> settled);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !settled |-> (cnt < CNT_W'(SETTLE_CYCLES)));
endmodule

// File: rtl/imp_hiz_window.sv
module imp_hiz_window
    import imp_seq_pkg::*;
(
    input  bus_ops_t ops,
    input  logic     settled,
    output logic     open_win
);
    win_src_e src;

    // R3, R5, R6, R7: any high-impedance reason opens the window
    always_comb begin
        src      = classify(ops, !settled);
        open_win = (src != WIN_NONE);
    end

    // R4
    always_comb begin
        if (settled && !ops_hiz(ops))
            closed_when_driving_chk: assert (!open_win);
    end
endmodule

// File: rtl/imp_code_reg.sv
module imp_code_reg #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] drv_code,
    output logic              upd_strobe
);
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

    // R1, R10
    always_ff @(posedge clk) begin
        if (rst) begin
            drv_code   <= MAX_CODE;
            upd_strobe <= 1'b0;
        end else begin
            upd_strobe <= load && (target != drv_code);
            if (load) drv_code <= target;
        end
    end

    // R10
    strobe_on_change_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_code != $past(drv_code)) |-> upd_strobe);

    // R10
    no_strobe_if_same_chk: assert property (@(posedge clk) disable iff (rst)
        (load && target == drv_code) |=> !upd_strobe);
endmodule

// File: rtl/imp_update_seq.sv
module imp_update_seq
    import imp_seq_pkg::*;
#(
    parameter int CODE_W        = 6,
    parameter int SETTLE_CYCLES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] cal_code,
    input  logic              ref_open,
    input  logic              wr_op,
    input  logic              desel_op,
    input  logic              oe_off,
    output logic [CODE_W-1:0] drv_code,
    output logic              settled,
    output logic              upd_strobe
);
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

    bus_ops_t          ops;
    logic [CODE_W-1:0] target;
    logic              open_win;

    always_comb begin
        ops.wr     = wr_op;
        ops.desel  = desel_op;
        ops.oe_off = oe_off;
    end

    imp_target_sel #(.CODE_W(CODE_W)) u_sel (
        .cal_code (cal_code),
        .ref_open (ref_open),
        .target   (target)
    );

    imp_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .settled (settled)
    );

    imp_hiz_window u_win (
        .ops      (ops),
        .settled  (settled),
        .open_win (open_win)
    );

    imp_code_reg #(.CODE_W(CODE_W)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .load       (open_win),
        .target     (target),
        .drv_code   (drv_code),
        .upd_strobe (upd_strobe)
    );

    // R4
    hold_while_driving_chk: assert property (@(posedge clk) disable iff (rst)
        (settled && !wr_op && !desel_op && !oe_off) |=> $stable(drv_code));

    // R8
    open_ref_max_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_open && (wr_op || desel_op || oe_off || !settled)) |=> (drv_code == MAX_CODE));

    // R3
    settling_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        (!settled && !ref_open) |=> (drv_code == $past(cal_code)));
endmodule

// File: tb/imp_update_seq_bench.sv
module imp_update_seq_bench;
    localparam int CW = 6;
    localparam int SC = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b0;
    logic [CW-1:0] cal_code = '0;
    logic          ref_open = 1'b0;
    logic          wr_op = 1'b0;
    logic          desel_op = 1'b0;
    logic          oe_off = 1'b0;
    logic [CW-1:0] drv_code;
    logic          settled;
    logic          upd_strobe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    imp_update_seq #(.CODE_W(CW), .SETTLE_CYCLES(SC)) u_imp_update_seq (
        .clk(clk), .rst(rst), .cal_code(cal_code), .ref_open(ref_open),
        .wr_op(wr_op), .desel_op(desel_op), .oe_off(oe_off),
        .drv_code(drv_code), .settled(settled), .upd_strobe(upd_strobe)
    );

    // reference model state
    logic [CW-1:0] m_code;
    logic          m_set;
    int            m_cnt;

    // scoreboard queues
    logic [CW-1:0] q_code[$];
    logic          q_set[$];
    logic          q_stb[$];
    string         q_tag[$];

    task automatic model_reset();
        m_code = '1;
        m_set  = 1'b0;
        m_cnt  = 0;
    endtask

    // driver: called at a falling edge, drives one cycle and pushes the expectation
    task automatic step(input logic [CW-1:0] c, input logic op, input logic w,
                        input logic d, input logic o, input string tag);
        logic          hiz;
        logic [CW-1:0] tgt;
        logic          stb;
        cal_code = c; ref_open = op; wr_op = w; desel_op = d; oe_off = o;
        hiz = w | d | o | !m_set;
        tgt = op ? '1 : c;
        stb = hiz && (tgt != m_code);
        if (hiz) m_code = tgt;
        if (!m_set) begin
            if (m_cnt == SC - 1) m_set = 1'b1;
            m_cnt++;
        end
        q_code.push_back(m_code);
        q_set.push_back(m_set);
        q_stb.push_back(stb);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    // monitor: compares shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_code.size() > 0) begin
                logic [CW-1:0] ec;
                logic          es, eb;
                string         t;
                ec = q_code.pop_front();
                es = q_set.pop_front();
                eb = q_stb.pop_front();
                t  = q_tag.pop_front();
                checks++;
                if (drv_code !== ec || settled !== es || upd_strobe !== eb) begin
                    fails++;
                    $display("FAIL %s code=%0d exp=%0d settled=%0b exp=%0b strobe=%0b exp=%0b",
                             t, drv_code, ec, settled, es, upd_strobe, eb);
                end
            end
        end
    end

    task automatic do_reset(input string tag);
        rst = 1'b1;
        cal_code = 6'd9; ref_open = 1'b0; wr_op = 1'b1; desel_op = 1'b0; oe_off = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (drv_code !== '1 || settled !== 1'b0 || upd_strobe !== 1'b0) begin
            fails++;
            $display("FAIL %s reset code=%0d exp=%0d settled=%0b exp=0 strobe=%0b exp=0",
                     tag, drv_code, 6'h3f, settled, upd_strobe);
        end
        rst = 1'b0;
        wr_op = 1'b0;
        model_reset();
    endtask

    initial begin
        #(150000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset("R1");

        // settling: code follows every edge, forced code on some cycles
        for (int i = 0; i < SC; i++) begin
            logic op;
            op = (i % 97 == 5);
            if (i >= SC - 3)
                step(CW'((i * 7) % 60), 1'b0, 1'b0, 1'b0, 1'b0, "R2");
            else if (op)
                step(CW'((i * 7) % 60), 1'b1, 1'b0, 1'b0, 1'b0, "R8");
            else
                step(CW'((i * 7) % 60), 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        end

        // settled: read cycles must not disturb the code
        step(6'd3,  1'b0, 1'b0, 1'b0, 1'b0, "R4");
        step(6'd44, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        step(6'd12, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        step(6'd12, 1'b0, 1'b0, 1'b0, 1'b0, "R2");

        // pending: several changes during reads, latest applied at write
        step(6'd10, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        step(6'd20, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        step(6'd20, 1'b0, 1'b1, 1'b0, 1'b0, "R9");

        step(6'd5,  1'b0, 1'b1, 1'b0, 1'b0, "R5");
        step(6'd7,  1'b0, 1'b0, 1'b0, 1'b0, "R4");
        step(6'd40, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
        step(6'd17, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
        step(6'd2,  1'b1, 1'b1, 1'b0, 1'b0, "R8");
        step(6'd2,  1'b1, 1'b0, 1'b1, 1'b0, "R10");
        step(6'd2,  1'b0, 1'b0, 1'b0, 1'b1, "R10");
        step(6'd2,  1'b0, 1'b0, 1'b0, 1'b0, "R10");

        // reset again mid-run: settled must drop and code return to maximum
        do_reset("R2");
        step(6'd33, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        step(6'd34, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        step(6'd34, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
        @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule